// File: doc/BRIEF.md
# Device Controller Command/Status Sequencer

This block is a register-mapped device controller. A processor reaches it through a simple register bus with select, write enable, address and write data. The controller holds a command register, a status register and a small bank of data registers. Software loads an operand into the first data register and then writes a command code. The controller moves from idle to working, runs a device back end for a number of cycles that depends on the operand, and then reports finished. At that point it raises an interrupt request, so software does not have to poll.

Software acknowledges completion by writing the status register with its done bit set. This returns the controller to idle and drops the interrupt. No new command is taken until that happens. A command that arrives at the wrong time, or that carries an unknown code, is refused and leaves an error code in the status register. The device back end is modelled inside the block as a responder with variable latency. A read command leaves a computed result in the first data register.

Top module: `devctl_top`

## Requirements
- R1: After reset, every mapped register reads zero, the error code is zero and `irq` is low.
- R2: Status bit 0 is busy and bit 1 is done. (0,0) means idle, (1,0) means working and (0,1) means finished. Busy and done are never both set. Status bits [5:4] hold the error code, and all other status bits read zero.
- R3: Address 0 is the command register. A command code (bits [3:0]) of 2 is WRITE. Written while idle, it makes the controller busy for exactly 2 + (D mod 8) cycles, where D is the value of data register 0 at the command write. Data register 0 keeps D.
- R4: A command code of 1 is READ. It behaves like WRITE, and data register 0 holds (3·D + 1) mod 2^16 once done is reported.
- R5: `irq` is high exactly while the controller is finished. It rises on the same edge that done sets.
- R6: Writing status (address 1) with bit 1 set while finished returns the controller to idle and drops `irq`. A status write with bit 1 clear, or a status write in any other state, has no effect.
- R7: A command written while working or finished is ignored. The state, `irq` and the data registers keep their values, and the error code becomes 2.
- R8: A command code from 3 to 15 written while idle leaves the controller idle and sets error code 1.
- R9: Command code 0 (no operation) written while idle is accepted. It leaves the controller idle without setting done.
- R10: Any accepted command clears the error code. The error code otherwise holds until reset.
- R11: Reads return data one cycle after the request, together with `bus_rvalid`. Data registers 0 to 3 sit at addresses 2 to 5 and can be read and written. The command register reads back the last accepted code. Unmapped addresses read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Register access request |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, valid one cycle after the request |
| bus_rvalid | output | 1 | Read data valid |
| irq | output | 1 | Completion interrupt request |

## Verification
The situations that are hard to reach from the ports are a command or an acknowledge that lands while the device is still working, and a second command that arrives while completion has not yet been acknowledged. The stimulus loads an operand that gives the longest latency, so the bus has time to issue a refused command, a status read and an early acknowledge before the device finishes. A second refused command is then sent before the acknowledge. A sweep over every value of the latency-selecting operand bits checks the busy time cycle by cycle, using the interrupt line for both read and write commands.

// File: rtl/devctl_pkg.sv
package devctl_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WORK = 2'd1,
    ST_FIN  = 2'd2
  } ctl_state_e;

  typedef enum logic [1:0] {
    ERR_NONE    = 2'd0,
    ERR_BADCODE = 2'd1,
    ERR_BUSY    = 2'd2
  } err_code_e;

  localparam int CMD_W = 4;
  localparam logic [CMD_W-1:0] CMD_NOP   = 4'd0;
  localparam logic [CMD_W-1:0] CMD_READ  = 4'd1;
  localparam logic [CMD_W-1:0] CMD_WRITE = 4'd2;

  localparam int ADDR_CMD   = 0;
  localparam int ADDR_STAT  = 1;
  localparam int ADDR_DATA0 = 2;

  localparam int STAT_BUSY_BIT = 0;
  localparam int STAT_DONE_BIT = 1;
  localparam int STAT_ERR_LSB  = 4;

  // Result produced by the modelled device for a read command.
  function automatic logic [31:0] dev_read_value(input logic [31:0] operand);
    return (operand << 1) + operand + 32'd1;
  endfunction

  // Busy time in cycles for a given operand.
  function automatic logic [31:0] dev_cycles(input logic [31:0] lat_min,
                                             input logic [31:0] operand,
                                             input int unsigned lat_w);
    logic [31:0] mask;
    mask = (32'd1 << lat_w) - 32'd1;
    return lat_min + (operand & mask);
  endfunction

endpackage

// File: rtl/devctl_dev.sv
module devctl_dev
  import devctl_pkg::*;
#(
  parameter int DW      = 16,
  parameter int LAT_MIN = 2,
  parameter int LAT_W   = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          is_read,
  input  logic [DW-1:0] operand,
  output logic          complete,
  output logic          res_we,
  output logic [DW-1:0] result
);
  localparam int CNT_W = $clog2(LAT_MIN + (1 << LAT_W) + 1);

  logic [CNT_W-1:0] remain;
  logic             rd_q;
  logic [DW-1:0]    res_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      remain <= '0;
      rd_q   <= 1'b0;
      res_q  <= '0;
    end else if (start) begin
      remain <= CNT_W'(dev_cycles(32'(LAT_MIN), 32'(operand), LAT_W));
      rd_q   <= is_read;
      res_q  <= DW'(dev_read_value(32'(operand)));
    end else if (remain != '0) begin
      remain <= remain - 1'b1;
    end
  end

  assign complete = (remain == CNT_W'(1));
  assign res_we   = complete & rd_q;
  assign result   = res_q;

  a_r3_latency_floor: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (remain >= CNT_W'(LAT_MIN)));
  a_r3_no_restart_while_running: assert property (@(posedge clk) disable iff (!rst_n)
    (remain > CNT_W'(1)) |-> !start);

endmodule

// File: rtl/devctl_seq.sv
module devctl_seq
  import devctl_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_wr,
  input  logic [CMD_W-1:0] cmd_code,
  input  logic             ack_wr,
  input  logic             complete,
  output ctl_state_e       state,
  output err_code_e        err,
  output logic [CMD_W-1:0] last_cmd,
  output logic             start,
  output logic             start_read,
  output logic             cmd_accept,
  output logic             cmd_reject_busy,
  output logic             cmd_reject_code,
  output logic             ack_evt
);
  logic       code_ok;
  ctl_state_e state_nx;

  assign code_ok         = (cmd_code == CMD_NOP) || (cmd_code == CMD_READ) ||
                           (cmd_code == CMD_WRITE);
  assign cmd_reject_busy = cmd_wr && (state != ST_IDLE);
  assign cmd_reject_code = cmd_wr && (state == ST_IDLE) && !code_ok;
  assign cmd_accept      = cmd_wr && (state == ST_IDLE) && code_ok;
  assign start           = cmd_accept && (cmd_code != CMD_NOP);
  assign start_read      = (cmd_code == CMD_READ);
  assign ack_evt         = ack_wr && (state == ST_FIN);

  always_comb begin
    state_nx = state;
    case (state)
      ST_IDLE: if (start)    state_nx = ST_WORK;
      ST_WORK: if (complete) state_nx = ST_FIN;
      ST_FIN:  if (ack_evt)  state_nx = ST_IDLE;
      default:               state_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      err      <= ERR_NONE;
      last_cmd <= '0;
    end else begin
      state <= state_nx;
      if (cmd_reject_busy)      err <= ERR_BUSY;
      else if (cmd_reject_code) err <= ERR_BADCODE;
      else if (cmd_accept)      err <= ERR_NONE;
      if (cmd_accept) last_cmd <= cmd_code;
    end
  end

  a_r2_state_legal: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE) || (state == ST_WORK) || (state == ST_FIN));
  a_r3_start_goes_busy: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (state == ST_WORK));
  a_r6_ack_returns_idle: assert property (@(posedge clk) disable iff (!rst_n)
    ack_evt |=> (state == ST_IDLE));
  a_r7_finished_holds_on_reject: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_reject_busy && state == ST_FIN) |=> (state == ST_FIN && err == ERR_BUSY));
  a_r8_badcode_stays_idle: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_reject_code |=> (state == ST_IDLE && err == ERR_BADCODE));
  a_r9_nop_stays_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_accept && cmd_code == CMD_NOP) |=> (state == ST_IDLE && err == ERR_NONE));

endmodule

// File: rtl/devctl_regfile.sv
module devctl_regfile
  import devctl_pkg::*;
#(
  parameter int DW    = 16,
  parameter int NDATA = 4,
  parameter int AW    = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_en,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  input  logic          dev_we,
  input  logic [DW-1:0] dev_result,
  input  logic [DW-1:0] cmd_word,
  input  logic [DW-1:0] status_word,
  output logic [DW-1:0] rdata,
  output logic          rvalid,
  output logic [DW-1:0] data0
);
  logic [DW-1:0] data_q [NDATA];
  logic [DW-1:0] rd_mux;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NDATA; i++) data_q[i] <= '0;
    end else begin
      for (int i = 0; i < NDATA; i++) begin
        if (i == 0 && dev_we)
          data_q[i] <= dev_result;
        else if (wr_en && addr == AW'(ADDR_DATA0 + i))
          data_q[i] <= wdata;
      end
    end
  end

  always_comb begin
    rd_mux = '0;
    if (addr == AW'(ADDR_CMD))  rd_mux = cmd_word;
    if (addr == AW'(ADDR_STAT)) rd_mux = status_word;
    for (int i = 0; i < NDATA; i++)
      if (addr == AW'(ADDR_DATA0 + i)) rd_mux = data_q[i];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdata  <= '0;
      rvalid <= 1'b0;
    end else begin
      rvalid <= rd_en;
      if (rd_en) rdata <= rd_mux;
    end
  end

  assign data0 = data_q[0];

  a_r11_rvalid_follows_read: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rvalid);
  a_r11_no_spurious_rvalid: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> !rvalid);
  a_r4_result_lands: assert property (@(posedge clk) disable iff (!rst_n)
    dev_we |=> (data0 == $past(dev_result)));

endmodule

// File: rtl/devctl_top.sv
module devctl_top
  import devctl_pkg::*;
#(
  parameter int DW      = 16,
  parameter int NDATA   = 4,
  parameter int LAT_MIN = 2,
  parameter int LAT_W   = 3,
  parameter int AW      = $clog2(NDATA + ADDR_DATA0)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_sel,
  input  logic          bus_wr,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic          bus_rvalid,
  output logic          irq
);
  logic             wr_en, rd_en, cmd_wr, ack_wr;
  ctl_state_e       state;
  err_code_e        err;
  logic [CMD_W-1:0] last_cmd;
  logic             start, start_read, cmd_accept;
  logic             cmd_reject_busy, cmd_reject_code, ack_evt;
  logic             complete, res_we;
  logic [DW-1:0]    dev_result, data0, cmd_word, status_word;
  logic             busy, done;

  assign wr_en  = bus_sel && bus_wr;
  assign rd_en  = bus_sel && !bus_wr;
  assign cmd_wr = wr_en && (bus_addr == AW'(ADDR_CMD));
  assign ack_wr = wr_en && (bus_addr == AW'(ADDR_STAT)) && bus_wdata[STAT_DONE_BIT];

  assign busy = (state == ST_WORK);
  assign done = (state == ST_FIN);
  assign irq  = done;

  always_comb begin
    status_word = '0;
    status_word[STAT_BUSY_BIT] = busy;
    status_word[STAT_DONE_BIT] = done;
    status_word[STAT_ERR_LSB +: 2] = err;
    cmd_word = '0;
    cmd_word[CMD_W-1:0] = last_cmd;
  end

  devctl_seq u_seq (
    .clk             (clk),
    .rst_n           (rst_n),
    .cmd_wr          (cmd_wr),
    .cmd_code        (bus_wdata[CMD_W-1:0]),
    .ack_wr          (ack_wr),
    .complete        (complete),
    .state           (state),
    .err             (err),
    .last_cmd        (last_cmd),
    .start           (start),
    .start_read      (start_read),
    .cmd_accept      (cmd_accept),
    .cmd_reject_busy (cmd_reject_busy),
    .cmd_reject_code (cmd_reject_code),
    .ack_evt         (ack_evt)
  );

  devctl_dev #(.DW(DW), .LAT_MIN(LAT_MIN), .LAT_W(LAT_W)) u_dev (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .is_read  (start_read),
    .operand  (data0),
    .complete (complete),
    .res_we   (res_we),
    .result   (dev_result)
  );

  devctl_regfile #(.DW(DW), .NDATA(NDATA), .AW(AW)) u_regs (
    .clk         (clk),
    .rst_n       (rst_n),
    .rd_en       (rd_en),
    .wr_en       (wr_en),
    .addr        (bus_addr),
    .wdata       (bus_wdata),
    .dev_we      (res_we),
    .dev_result  (dev_result),
    .cmd_word    (cmd_word),
    .status_word (status_word),
    .rdata       (bus_rdata),
    .rvalid      (bus_rvalid),
    .data0       (data0)
  );

  a_r2_never_busy_and_done: assert property (@(posedge clk) disable iff (!rst_n)
    !(status_word[STAT_BUSY_BIT] && status_word[STAT_DONE_BIT]));
  a_r5_irq_rises_from_working: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(busy));
  a_r6_irq_drops_only_on_ack: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq) |-> $past(ack_evt));
  a_r7_reject_keeps_irq: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_reject_busy && irq) |=> irq);
  a_r10_accept_clears_err: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_accept |=> (status_word[STAT_ERR_LSB +: 2] == 2'd0));

endmodule

// File: tb/test_devctl_top.sv
module test_devctl_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sel = 1'b0;
  logic        wr = 1'b0;
  logic [2:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        rvalid;
  logic        irq;
  int n_total = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  devctl_top i_devctl_top (
    .clk(clk), .rst_n(rst_n), .bus_sel(sel), .bus_wr(wr), .bus_addr(addr),
    .bus_wdata(wdata), .bus_rdata(rdata), .bus_rvalid(rvalid), .irq(irq)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] got, input logic [31:0] exp);
    n_total++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, got, exp);
    end
  endtask

  task automatic bus_write(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    sel = 1'b1; wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    sel = 1'b0; wr = 1'b0;
  endtask

  task automatic bus_read(input logic [2:0] a, output logic [15:0] d, input string req);
    @(negedge clk);
    sel = 1'b1; wr = 1'b0; addr = a;
    @(negedge clk);
    sel = 1'b0;
    chk(req, "rvalid", {31'd0, rvalid}, 32'd1);
    d = rdata;
  endtask

  task automatic wait_irq(output int cycles);
    cycles = 0;
    while (!irq && cycles < 100) begin
      @(negedge clk);
      cycles++;
    end
  endtask

  function automatic int exp_lat(input logic [15:0] v);
    return 2 + int'(v % 16'd8);
  endfunction

  function automatic logic [15:0] exp_read(input logic [15:0] v);
    logic [17:0] s;
    s = {2'b00, v} + {2'b00, v} + {2'b00, v} + 18'd1;
    return s[15:0];
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_total++; n_bad++;
      $display("FAIL watchdog: run did not complete");
      $display("test done: total=%0d bad=%0d", n_total, n_bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] r;
    logic [15:0] v;
    int cyc;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    chk("R1", "irq after reset", {31'd0, irq}, 32'd0);
    for (int a = 0; a < 6; a++) begin
      bus_read(3'(a), r, "R1");
      chk("R1", "register zero after reset", {16'd0, r}, 32'd0);
    end

    // R11: data registers and unmapped addresses
    for (int a = 2; a < 6; a++) bus_write(3'(a), 16'(16'hA000 + a * 16'h0111));
    for (int a = 2; a < 6; a++) begin
      bus_read(3'(a), r, "R11");
      chk("R11", "data register readback", {16'd0, r}, {16'd0, 16'(16'hA000 + a * 16'h0111)});
    end
    for (int a = 6; a < 8; a++) begin
      bus_read(3'(a), r, "R11");
      chk("R11", "unmapped reads zero", {16'd0, r}, 32'd0);
    end

    // R3 R4 R5 R6: sweep latency bits for write and read commands
    for (int op = 1; op <= 2; op++) begin
      for (int k = 0; k <= 8; k++) begin
        v = (k == 8) ? 16'hFFFF : 16'(16'h0F00 * k + 16'h0040 + k);
        bus_write(3'd2, v);
        bus_write(3'd0, 16'(op));
        wait_irq(cyc);
        chk(op == 2 ? "R3" : "R4", "busy cycles", 32'(cyc), 32'(exp_lat(v)));
        chk("R5", "irq at done", {31'd0, irq}, 32'd1);
        bus_read(3'd1, r, "R2");
        chk("R2", "status finished", {16'd0, r}, 32'h0002);
        bus_read(3'd2, r, "R3");
        if (op == 2) chk("R3", "data0 kept", {16'd0, r}, {16'd0, v});
        else         chk("R4", "read result", {16'd0, r}, {16'd0, exp_read(v)});
        bus_read(3'd0, r, "R11");
        chk("R11", "command readback", {16'd0, r}, 32'(op));
        bus_write(3'd1, 16'h0001);
        @(negedge clk);
        chk("R6", "ack without done bit ignored", {31'd0, irq}, 32'd1);
        bus_write(3'd1, 16'h0002);
        chk("R6", "irq drops on ack", {31'd0, irq}, 32'd0);
        bus_read(3'd1, r, "R6");
        chk("R6", "status idle after ack", {16'd0, r}, 32'h0000);
      end
    end

    // R7 R6: refused command and early ack while working, longest latency
    bus_write(3'd2, 16'h0007);
    bus_write(3'd0, 16'h0002);
    bus_write(3'd0, 16'h0001);
    bus_write(3'd1, 16'h0002);
    bus_read(3'd1, r, "R7");
    chk("R7", "working with busy error", {16'd0, r}, 32'h0021);
    chk("R6", "early ack no irq", {31'd0, irq}, 32'd0);
    wait_irq(cyc);
    chk("R6", "still completes after early ack", {31'd0, irq}, 32'd1);
    bus_read(3'd2, r, "R7");
    chk("R7", "refused read left data0", {16'd0, r}, 32'h0007);
    bus_write(3'd0, 16'h0002);
    chk("R7", "irq held after refused command", {31'd0, irq}, 32'd1);
    bus_read(3'd1, r, "R7");
    chk("R7", "finished with busy error", {16'd0, r}, 32'h0022);
    bus_write(3'd1, 16'h0002);
    bus_read(3'd1, r, "R10");
    chk("R10", "error held after ack", {16'd0, r}, 32'h0020);

    // R9 R10: no-operation command
    bus_write(3'd0, 16'h0000);
    repeat (4) @(negedge clk);
    chk("R9", "nop raises no irq", {31'd0, irq}, 32'd0);
    bus_read(3'd1, r, "R9");
    chk("R9", "nop idle and error cleared", {16'd0, r}, 32'h0000);

    // R8: every unknown command code
    for (int c = 3; c < 16; c++) begin
      bus_write(3'd0, 16'(c));
      bus_read(3'd1, r, "R8");
      chk("R8", "bad code idle with error 1", {16'd0, r}, 32'h0010);
      chk("R8", "bad code no irq", {31'd0, irq}, 32'd0);
    end

    // R10: accepted write clears error 1
    bus_write(3'd2, 16'h0007);
    bus_write(3'd0, 16'h0002);
    bus_read(3'd1, r, "R10");
    chk("R10", "accepted command clears error", {16'd0, r}, 32'h0001);
    wait_irq(cyc);
    bus_write(3'd1, 16'h0002);
    chk("R6", "final ack", {31'd0, irq}, 32'd0);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", n_total, n_bad);
    $finish;
  end
endmodule